// File: doc/BRIEF.md
# Power-Change Maintenance Interrupt Generator and Router

This block raises a system maintenance interrupt when software changes the power setting of a card socket. Each of the two sockets has a write strobe for its socket control register and for its power control register, plus a one-cycle "sequence launched" pulse. The pulse marks the cycle in which the serial protocol to the external power switch actually starts. A write arms the socket. A launch pulse that finds the socket armed (or that comes together with the arming write) consumes the arm. If generation is enabled, it also sets that socket's pending flag.

Software reaches the block through three bits of a 32-bit system control word, delivered as the slice of bits 26 down to 24 together with the number of the socket function that performed the write. The enable bit and the route bit are shared by both socket functions. The pending status bit belongs to each socket and is cleared by writing 1 to it.

Pending flags go out on one of two routes:
- **Per-socket card status change line.** The line is level or edge style, chosen per socket.
- **IRQ2 request.** The request goes to a serialized IRQ agent. It can also drive an active-low parallel pin, but only when IRQ2 is mapped to multifunction pin 3 or pin 6.

Top module: `smiPowerIrq`

## Requirements
- R1: After reset, both pending flags, the enable bit and the route bit are 0, both card status change outputs and `irq2Serial` are low, and all seven `mfPinN` bits are high.
- R2: A configuration write from either socket function loads the enable bit from `cfgCtlBits[24]` and the route bit from `cfgCtlBits[26]`. These shared values appear on `smiEnOut` and `smiRouteOut` the cycle after the write.
- R3: A socket's `seqLaunch` pulse, arriving while that socket is armed, sets its pending flag the following cycle when enable is 1.
  - A pulse on `sockCtrlWr` or `pwrCtrlWr` arms the socket. The arm stays in place until a launch pulse consumes it.
  - A launch in the same cycle as the arming write also counts.
  - A launch that finds the socket unarmed is ignored.
- R4: While enable is 0, launch pulses leave the pending flags unchanged and still consume the arm.
- R5: A configuration write with `cfgCtlBits[25]`=1 clears the pending flag of the socket named by `cfgSock` only. A write with `cfgCtlBits[25]`=0 leaves both pending flags unchanged.
- R6: When a set event and a write-1 clear hit the same socket in the same cycle, the pending flag ends up set.
- R7: With route = 0 and `cscEdgeMode[i]`=0, `cscIrq[i]` is high for exactly as long as pending flag i is set.
- R8: With route = 0 and `cscEdgeMode[i]`=1, `cscIrq[i]` is high for the single cycle in which pending flag i first reads 1, and low afterwards while the flag stays set.
- R9: With route = 1, both `cscIrq` bits are low and `irq2Serial` is the OR of the two pending flags.
- R10: With route = 1 and at least one flag pending, `mfPinN[irq2PinSel]` is driven low only when `irq2PinSel` is 3 or 6. All other pins stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sockCtrlWr | input | 2 | Per-socket write strobe of the socket control register |
| pwrCtrlWr | input | 2 | Per-socket write strobe of the power control register |
| seqLaunch | input | 2 | Per-socket pulse: power-switch sequence launched |
| cfgWr | input | 1 | Write strobe of the system control word |
| cfgSock | input | 1 | Socket function performing the configuration write |
| cfgCtlBits | input | 3 | Bits 26:24 of the control word (route, status, enable) |
| cscEdgeMode | input | 2 | Per-socket card status change style: 1 edge, 0 level |
| irq2PinSel | input | 3 | Multifunction pin number that IRQ2 is mapped to |
| smiEnOut | output | 1 | Shared enable bit |
| smiRouteOut | output | 1 | Shared route bit: 1 IRQ2, 0 card status change |
| smiPend | output | 2 | Per-socket pending flags |
| cscIrq | output | 2 | Per-socket card status change interrupt |
| irq2Serial | output | 1 | IRQ2 request to the serialized IRQ agent |
| mfPinN | output | 7 | Active-low parallel IRQ2 on multifunction pins 0..6 |

## Verification
The bench covers the following corner cases, and what a faulty design would do in each:
- **Arm sequencing.** The bench checks a launch with no prior write, an arming write in the same cycle as the launch, and an arm that waits several cycles for its launch. A design that ignored the arm, or never consumed it, would raise a flag on a stray launch.
- **Clear collisions.** The bench aims a write-1 clear at the other socket, writes the status bit as 0, and clears in the same cycle as a set. A wrong design would clear the wrong socket or lose the new interrupt.
- **Edge-mode pulse.** The bench holds the flag set after an edge-mode pulse. A pulse stretched into a level would show up there.
- **IRQ2 pin selection.** The bench maps IRQ2 to legal and illegal pins in turn. A design that honoured an illegal pin number would drive a pin low that it must not.

// File: rtl/smiPkg.sv
package smiPkg;
  localparam int SockCnt  = 2;
  localparam int SockW    = (SockCnt > 1) ? $clog2(SockCnt) : 1;
  localparam int RouteBit = 26;
  localparam int StatBit  = 25;
  localparam int EnBit    = 24;
  localparam int PinCnt   = 7;
  localparam int PinSelW  = $clog2(PinCnt);
  localparam int IrqPinA  = 3;
  localparam int IrqPinB  = 6;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic [SockCnt-1:0] setPend;
    logic [SockCnt-1:0] clrPend;
    logic               cfgLoad;
    logic               enVal;
    logic               routeVal;
  } smiStrobe_t;
endpackage

// File: rtl/smiCtrl.sv
module smiCtrl
  import smiPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SockCnt-1:0]      sockCtrlWr,
  input  logic [SockCnt-1:0]      pwrCtrlWr,
  input  logic [SockCnt-1:0]      seqLaunch,
  input  logic                    cfgWr,
  input  logic [SockW-1:0]        cfgSock,
  input  logic [RouteBit:EnBit]   cfgCtlBits,
  input  logic                    smiEn,
  output smiStrobe_t              strobe
);

  logic [SockCnt-1:0] armed;
  logic [SockCnt-1:0] armNow;
  logic [SockCnt-1:0] setVec;
  logic [SockCnt-1:0] clrVec;

  genvar s;
  generate
    for (s = 0; s < SockCnt; s++) begin : gSock
      // a power-related write arms the socket; the launch consumes the arm
      assign armNow[s] = armed[s] | sockCtrlWr[s] | pwrCtrlWr[s];
      assign setVec[s] = seqLaunch[s] & armNow[s] & smiEn;
      assign clrVec[s] = cfgWr & cfgCtlBits[StatBit] & (cfgSock == SockW'(s));

      always_ff @(posedge clk) begin
        if (!rstN) armed[s] <= 1'b0;
        else       armed[s] <= armNow[s] & ~seqLaunch[s];
      end

      AST_SET_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
        strobe.setPend[s] |-> (seqLaunch[s] && smiEn)); // R3

      AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
        !smiEn |-> !strobe.setPend[s]); // R4
    end
  endgenerate

  always_comb begin
    strobe.setPend  = setVec;
    strobe.clrPend  = clrVec;
    strobe.cfgLoad  = cfgWr;
    strobe.enVal    = cfgCtlBits[EnBit];
    strobe.routeVal = cfgCtlBits[RouteBit];
  end

endmodule

// File: rtl/smiDatapath.sv
module smiDatapath
  import smiPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  smiStrobe_t           strobe,
  input  logic [SockCnt-1:0]   cscEdgeMode,
  input  logic [PinSelW-1:0]   irq2PinSel,
  output logic                 smiEn,
  output logic                 smiRoute,
  output logic [SockCnt-1:0]   smiPend,
  output logic [SockCnt-1:0]   cscIrq,
  output logic                 irq2Serial,
  output logic [PinCnt-1:0]    mfPinN
);

  logic               enReg;
  logic               routeReg;
  logic [SockCnt-1:0] pendReg;
  logic [SockCnt-1:0] prevPend;
  logic               irq2Active;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      routeReg <= 1'b0;
    end else if (strobe.cfgLoad) begin
      enReg    <= strobe.enVal;
      routeReg <= strobe.routeVal;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SockCnt; s++) begin : gSock
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pendReg[s]  <= 1'b0;
          prevPend[s] <= 1'b0;
        end else begin
          // set has priority over write-one-to-clear
          pendReg[s]  <= strobe.setPend[s] | (pendReg[s] & ~strobe.clrPend[s]);
          prevPend[s] <= pendReg[s];
        end
      end

      logic edgeHit;
      assign edgeHit   = pendReg[s] & ~prevPend[s];
      assign cscIrq[s] = ~routeReg & (cscEdgeMode[s] ? edgeHit : pendReg[s]);

      AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
        (pendReg[s] && !$past(pendReg[s])) |-> $past(enReg)); // R4

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
        $past(strobe.setPend[s]) |-> pendReg[s]); // R6

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
        $past(strobe.clrPend[s] && !strobe.setPend[s]) |-> !pendReg[s]); // R5

      AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
        (cscEdgeMode[s] && $past(cscEdgeMode[s]) && $past(cscIrq[s])) |-> !cscIrq[s]); // R8
    end
  endgenerate

  assign irq2Active = routeReg & (|pendReg);
  assign irq2Serial = irq2Active;

  genvar p;
  generate
    for (p = 0; p < PinCnt; p++) begin : gPin
      if (p == IrqPinA || p == IrqPinB) begin : gLegal
        assign mfPinN[p] = ~(irq2Active & (irq2PinSel == PinSelW'(p)));
      end else begin : gIdle
        assign mfPinN[p] = 1'b1;
      end
    end
  endgenerate

  assign smiEn    = enReg;
  assign smiRoute = routeReg;
  assign smiPend  = pendReg;

endmodule

// File: rtl/smiPowerIrq.sv
module smiPowerIrq
  import smiPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SockCnt-1:0]    sockCtrlWr,
  input  logic [SockCnt-1:0]    pwrCtrlWr,
  input  logic [SockCnt-1:0]    seqLaunch,
  input  logic                  cfgWr,
  input  logic [SockW-1:0]      cfgSock,
  input  logic [RouteBit:EnBit] cfgCtlBits,
  input  logic [SockCnt-1:0]    cscEdgeMode,
  input  logic [PinSelW-1:0]    irq2PinSel,
  output logic                  smiEnOut,
  output logic                  smiRouteOut,
  output logic [SockCnt-1:0]    smiPend,
  output logic [SockCnt-1:0]    cscIrq,
  output logic                  irq2Serial,
  output logic [PinCnt-1:0]     mfPinN
);

  smiStrobe_t strobe;
  logic       enWire;

  smiCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sockCtrlWr (sockCtrlWr),
    .pwrCtrlWr  (pwrCtrlWr),
    .seqLaunch  (seqLaunch),
    .cfgWr      (cfgWr),
    .cfgSock    (cfgSock),
    .cfgCtlBits (cfgCtlBits),
    .smiEn      (enWire),
    .strobe     (strobe)
  );

  smiDatapath uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cscEdgeMode (cscEdgeMode),
    .irq2PinSel  (irq2PinSel),
    .smiEn       (enWire),
    .smiRoute    (smiRouteOut),
    .smiPend     (smiPend),
    .cscIrq      (cscIrq),
    .irq2Serial  (irq2Serial),
    .mfPinN      (mfPinN)
  );

  assign smiEnOut = enWire;

  AST_ONE_PIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~mfPinN) <= 1); // R10

  AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    irq2Serial |-> (cscIrq == '0)); // R9

  AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWr) |-> (smiEnOut == $past(cfgCtlBits[EnBit]))); // R2

endmodule

// File: tb/tb_smiPowerIrq.sv
module tb_smiPowerIrq;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] sockCtrlWr, pwrCtrlWr, seqLaunch;
  logic       cfgWr;
  logic [0:0] cfgSock;
  logic [26:24] cfgCtlBits;
  logic [1:0] cscEdgeMode;
  logic [2:0] irq2PinSel;
  logic       smiEnOut, smiRouteOut, irq2Serial;
  logic [1:0] smiPend, cscIrq;
  logic [6:0] mfPinN;

  int applied = 0;
  int errors  = 0;

  always #4 clk = ~clk; // 125 MHz

  smiPowerIrq dut (
    .clk(clk), .rstN(rstN), .sockCtrlWr(sockCtrlWr), .pwrCtrlWr(pwrCtrlWr),
    .seqLaunch(seqLaunch), .cfgWr(cfgWr), .cfgSock(cfgSock), .cfgCtlBits(cfgCtlBits),
    .cscEdgeMode(cscEdgeMode), .irq2PinSel(irq2PinSel), .smiEnOut(smiEnOut),
    .smiRouteOut(smiRouteOut), .smiPend(smiPend), .cscIrq(cscIrq),
    .irq2Serial(irq2Serial), .mfPinN(mfPinN)
  );

  typedef struct packed {
    logic [1:0] ctrl; logic [1:0] pwr; logic [1:0] launch;
    logic cfg; logic sock; logic route; logic stat; logic en;
    logic [1:0] edgeM; logic [2:0] sel;
    logic [1:0] xPend; logic [1:0] xCsc; logic xSer; logic xEn; logic xRoute;
    logic [6:0] xPin; logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    //ctrl  pwr    lnch   cfg  sk   rt   st   en   edge   sel    pend   csc    ser  en   rt   pins        req
    '{2'b01,2'b00,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'd0,2'b00,2'b00,1'b0,1'b0,1'b0,7'h7F,4'd4}, // R4 disabled launch
    '{2'b00,2'b00,2'b00,1'b1,1'b1,1'b0,1'b0,1'b1,2'b00,3'd0,2'b00,2'b00,1'b0,1'b1,1'b0,7'h7F,4'd2}, // R2 enable via socket 1
    '{2'b00,2'b00,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'd0,2'b00,2'b00,1'b0,1'b1,1'b0,7'h7F,4'd3}, // R3 unarmed launch
    '{2'b00,2'b01,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'd0,2'b00,2'b00,1'b0,1'b1,1'b0,7'h7F,4'd3}, // R3 arm by power write
    '{2'b00,2'b00,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'd0,2'b01,2'b01,1'b0,1'b1,1'b0,7'h7F,4'd3}, // R3 launch sets
    '{2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'd0,2'b01,2'b01,1'b0,1'b1,1'b0,7'h7F,4'd7}, // R7 level held
    '{2'b00,2'b00,2'b00,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00,3'd0,2'b01,2'b01,1'b0,1'b1,1'b0,7'h7F,4'd5}, // R5 other socket
    '{2'b00,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0,1'b1,2'b00,3'd0,2'b01,2'b01,1'b0,1'b1,1'b0,7'h7F,4'd5}, // R5 write zero
    '{2'b00,2'b00,2'b00,1'b1,1'b0,1'b0,1'b1,1'b1,2'b00,3'd0,2'b00,2'b00,1'b0,1'b1,1'b0,7'h7F,4'd5}, // R5 clear
    '{2'b10,2'b00,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,3'd0,2'b10,2'b10,1'b0,1'b1,1'b0,7'h7F,4'd8}, // R8 pulse
    '{2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,3'd0,2'b10,2'b00,1'b0,1'b1,1'b0,7'h7F,4'd8}, // R8 pulse ends
    '{2'b00,2'b00,2'b00,1'b1,1'b0,1'b1,1'b0,1'b1,2'b10,3'd3,2'b10,2'b00,1'b1,1'b1,1'b1,7'h77,4'd10},// R10 pin 3
    '{2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,3'd6,2'b10,2'b00,1'b1,1'b1,1'b1,7'h3F,4'd10},// R10 pin 6
    '{2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,3'd2,2'b10,2'b00,1'b1,1'b1,1'b1,7'h7F,4'd10},// R10 illegal pin
    '{2'b01,2'b00,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,3'd6,2'b11,2'b00,1'b1,1'b1,1'b1,7'h3F,4'd9}, // R9 both pending
    '{2'b00,2'b00,2'b00,1'b1,1'b1,1'b1,1'b1,1'b1,2'b10,3'd6,2'b01,2'b00,1'b1,1'b1,1'b1,7'h3F,4'd9}, // R9 OR of flags
    '{2'b01,2'b00,2'b01,1'b1,1'b0,1'b1,1'b1,1'b1,2'b10,3'd6,2'b01,2'b00,1'b1,1'b1,1'b1,7'h3F,4'd6}, // R6 set wins
    '{2'b00,2'b00,2'b00,1'b1,1'b0,1'b0,1'b1,1'b1,2'b10,3'd6,2'b00,2'b00,1'b0,1'b1,1'b0,7'h7F,4'd5}, // R5 clear, route back
    '{2'b00,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10,3'd6,2'b00,2'b00,1'b0,1'b0,1'b0,7'h7F,4'd2}, // R2 disable
    '{2'b10,2'b00,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,3'd6,2'b00,2'b00,1'b0,1'b0,1'b0,7'h7F,4'd4}  // R4 ignored
  };

  task automatic idleInputs();
    sockCtrlWr = '0; pwrCtrlWr = '0; seqLaunch = '0; cfgWr = 1'b0;
    cfgSock = '0; cfgCtlBits = '0;
  endtask

  task automatic check(input int req, input logic [1:0] xPend, input logic [1:0] xCsc,
                       input logic xSer, input logic xEn, input logic xRoute,
                       input logic [6:0] xPin);
    applied++;
    if (smiPend !== xPend || cscIrq !== xCsc || irq2Serial !== xSer ||
        smiEnOut !== xEn || smiRouteOut !== xRoute || mfPinN !== xPin) begin
      errors++;
      $display("FAIL R%0d: got pend=%b csc=%b ser=%b en=%b rt=%b pin=%h exp pend=%b csc=%b ser=%b en=%b rt=%b pin=%h",
               req, smiPend, cscIrq, irq2Serial, smiEnOut, smiRouteOut, mfPinN,
               xPend, xCsc, xSer, xEn, xRoute, xPin);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; idleInputs(); cscEdgeMode = '0; irq2PinSel = '0;
    repeat (3) @(negedge clk);
    check(1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h7F); // R1 reset state
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sockCtrlWr = VEC[i].ctrl; pwrCtrlWr = VEC[i].pwr; seqLaunch = VEC[i].launch;
      cfgWr = VEC[i].cfg; cfgSock = VEC[i].sock;
      cfgCtlBits = {VEC[i].route, VEC[i].stat, VEC[i].en};
      cscEdgeMode = VEC[i].edgeM; irq2PinSel = VEC[i].sel;
      cycle();
      check(int'(VEC[i].req), VEC[i].xPend, VEC[i].xCsc, VEC[i].xSer,
            VEC[i].xEn, VEC[i].xRoute, VEC[i].xPin);
      idleInputs();
    end

    // R3: arm held across idle cycles before the launch
    cscEdgeMode = 2'b00; irq2PinSel = 3'd0;
    cfgWr = 1'b1; cfgCtlBits = 3'b001; cycle(); idleInputs();
    sockCtrlWr = 2'b01; cycle(); idleInputs();
    cycle(); cycle();
    check(3, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 7'h7F); // R3 not yet set
    seqLaunch = 2'b01; cycle(); idleInputs();
    check(3, 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 7'h7F); // R3 delayed launch

    // R1: reset in mid-run clears everything
    rstN = 1'b0; cycle();
    check(1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 7'h7F);
    rstN = 1'b1;

    // R3: reset drops the arm; a later launch alone is ignored
    pwrCtrlWr = 2'b10; rstN = 1'b0; cycle(); rstN = 1'b1; idleInputs();
    cfgWr = 1'b1; cfgCtlBits = 3'b001; cycle(); idleInputs();
    seqLaunch = 2'b10; cycle(); idleInputs();
    check(3, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 7'h7F);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule